// File: doc/BRIEF.md
# Predicated Vector-to-Scalar Issue Expander

This block takes one vector instruction and unrolls it into a stream of scalar micro-operations, one per enabled element, for an instruction FIFO. Element `i` of the vector works on register numbers formed by adding `i` to each base register number of the instruction (destination and both sources). A bit mask read from an integer register picks which elements run: bit `i` enables element `i`. Elements whose bit is clear are skipped entirely. They use no issue slot and send no write to their destination register, which keeps its old value. A later instruction can therefore use those registers without waiting.

The controller has four states. `S_IDLE` waits for an instruction, with `in_ready` high. On acceptance it moves to `S_RUN` if any element is enabled below the vector length, or else straight to `S_DONE`. `S_RUN` presents the lowest still-pending enabled element and stays in `S_RUN` while elements remain. It moves to `S_DONE` when the FIFO takes the last one, or to `S_FAULT` when the current element would address a register beyond the last architectural register. `S_DONE` and `S_FAULT` each last one cycle and then return to `S_IDLE`.

A priority encoder finds the next enabled element in the same cycle. Runs of disabled elements are therefore skipped without spending any cycles on them.

Top module: `pred_issue_expander`

## Requirements
- R1: For an accepted instruction, exactly one micro-op is issued for each set mask bit whose index is below the effective vector length, in ascending element order; clear mask bits produce no micro-op.
- R2: Elements at index at or above the vector length are never issued; a vector length above XLEN (32 by default) acts as XLEN.
- R3: A micro-op for element i carries the instruction opcode unchanged, destination register rd+i, sources rs1+i and rs2+i, and `uop_elem` equal to i.
- R4: The first micro-op is valid in the cycle right after acceptance, and each accepted micro-op is followed in the next cycle by the next enabled element, however many disabled elements lie between.
- R5: While `uop_valid` is high and `fifo_ready` is low, `uop_valid` stays high and every micro-op field stays unchanged in the next cycle.
- R6: `done` is high for exactly one cycle: the cycle after the last micro-op is accepted or, when no element is enabled (vector length zero or empty mask), the cycle after acceptance; `uop_valid` is low while `done` is high.
- R7: `in_ready` is high only in the idle state; `in_valid` at any other time is ignored and has no effect on the micro-op stream.
- R8: If any register number of the next enabled element would exceed NREG-1 (31 by default), that element and all later ones are not issued; `uop_valid` is low for one cycle, then `done` and `error` are high together for one cycle.
- R9: After reset `in_ready` is high and `uop_valid`, `done` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Vector instruction offered |
| in_ready | output | 1 | High in the idle state; the instruction is accepted when both are high |
| in_opcode | input | OPC_W | Opcode copied to every micro-op |
| in_rd | input | REG_W | Base destination register number |
| in_rs1 | input | REG_W | Base first source register number |
| in_rs2 | input | REG_W | Base second source register number |
| in_vl | input | VL_W | Vector length (elements) |
| in_mask | input | XLEN | Predicate bits, bit i enables element i |
| fifo_ready | input | 1 | Instruction FIFO can take a micro-op |
| uop_valid | output | 1 | Micro-op presented |
| uop_opcode | output | OPC_W | Micro-op opcode |
| uop_rd | output | REG_W | Micro-op destination register |
| uop_rs1 | output | REG_W | Micro-op first source register |
| uop_rs2 | output | REG_W | Micro-op second source register |
| uop_elem | output | IDX_W | Element index of the micro-op |
| done | output | 1 | One-cycle pulse at the end of an instruction |
| error | output | 1 | High with `done` when issue stopped on a register overflow |

## Verification
The first micro-op is due one cycle after the accepting edge. After that, each micro-op is due the cycle after its predecessor is taken, a stalled micro-op repeats each cycle until it is taken, and `done` is due the cycle after the last acceptance. On an overflow, `done` and `error` come two cycles after the last good acceptance, with an empty cycle between. The bench drives inputs shortly after each rising edge and samples at the falling edge. A behavioural model, built from a queue of expected element indices, is advanced once per cycle with the same inputs the design sees at the next edge. Every output is compared against that model in every cycle, so each result is checked in exactly the cycle it is due.

// File: rtl/pie_pkg.sv
package pie_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_DONE  = 2'd2,
        S_FAULT = 2'd3
    } pie_state_e;

    localparam int unsigned PIE_NOPS = 3;
    localparam int unsigned PIE_OP_RD  = 0;
    localparam int unsigned PIE_OP_RS1 = 1;
    localparam int unsigned PIE_OP_RS2 = 2;
endpackage

// File: rtl/pie_vl_window.sv
module pie_vl_window #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned VL_W = $clog2(XLEN + 1)
) (
    input  logic [VL_W-1:0] vl,
    output logic [XLEN-1:0] window
);
    // Bit i is enabled when i < vl; vl above XLEN enables every bit.
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        assign window[i] = (32'(vl) > 32'(i));
    end
endmodule

// File: rtl/pie_first_set.sv
module pie_first_set #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     bits,
    output logic [IDX_W-1:0] idx
);
    // Lowest set bit wins; scan downward so the last hit is the lowest.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pie_operand_gen.sv
module pie_operand_gen #(
    parameter int unsigned NREG  = 32,
    parameter int unsigned REG_W = $clog2(NREG),
    parameter int unsigned IDX_W = 5,
    parameter int unsigned NOPS  = 3
) (
    input  logic [NOPS-1:0][REG_W-1:0] base,
    input  logic [IDX_W-1:0]           idx,
    output logic [NOPS-1:0][REG_W-1:0] reg_out,
    output logic                       overflow
);
    localparam int unsigned SUM_W = ((REG_W > IDX_W) ? REG_W : IDX_W) + 1;

    logic [NOPS-1:0] op_ovf;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        logic [SUM_W-1:0] sum;
        assign sum        = SUM_W'(base[g]) + SUM_W'(idx);
        assign reg_out[g] = sum[REG_W-1:0];
        assign op_ovf[g]  = (sum > SUM_W'(NREG - 1));
    end

    assign overflow = |op_ovf;
endmodule

// File: rtl/pred_issue_expander.sv
module pred_issue_expander
    import pie_pkg::*;
#(
    parameter  int unsigned XLEN  = 32,
    parameter  int unsigned NREG  = 32,
    parameter  int unsigned OPC_W = 7,
    localparam int unsigned REG_W = $clog2(NREG),
    localparam int unsigned IDX_W = $clog2(XLEN),
    localparam int unsigned VL_W  = $clog2(XLEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OPC_W-1:0] in_opcode,
    input  logic [REG_W-1:0] in_rd,
    input  logic [REG_W-1:0] in_rs1,
    input  logic [REG_W-1:0] in_rs2,
    input  logic [VL_W-1:0]  in_vl,
    input  logic [XLEN-1:0]  in_mask,
    input  logic             fifo_ready,
    output logic             uop_valid,
    output logic [OPC_W-1:0] uop_opcode,
    output logic [REG_W-1:0] uop_rd,
    output logic [REG_W-1:0] uop_rs1,
    output logic [REG_W-1:0] uop_rs2,
    output logic [IDX_W-1:0] uop_elem,
    output logic             done,
    output logic             error
);
    pie_state_e state_q, state_nx;

    logic [OPC_W-1:0]                 opc_q;
    logic [PIE_NOPS-1:0][REG_W-1:0]   base_q;
    logic [XLEN-1:0]                  pend_q;

    logic [XLEN-1:0]                  vl_window;
    logic [XLEN-1:0]                  eff_mask;
    logic [IDX_W-1:0]                 cur_idx;
    logic [XLEN-1:0]                  cur_bit;
    logic [XLEN-1:0]                  pend_after;
    logic [PIE_NOPS-1:0][REG_W-1:0]   cur_regs;
    logic                             cur_ovf;
    logic                             accept_in;
    logic                             issue_fire;

    // Mask of elements below the vector length.
    pie_vl_window #(
        .XLEN (XLEN),
        .VL_W (VL_W)
    ) u_window (
        .vl     (in_vl),
        .window (vl_window)
    );

    assign eff_mask = in_mask & vl_window;

    // Next pending element.
    pie_first_set #(
        .W     (XLEN),
        .IDX_W (IDX_W)
    ) u_first (
        .bits (pend_q),
        .idx  (cur_idx)
    );

    // Register numbers for that element and range check.
    pie_operand_gen #(
        .NREG  (NREG),
        .REG_W (REG_W),
        .IDX_W (IDX_W),
        .NOPS  (PIE_NOPS)
    ) u_operands (
        .base     (base_q),
        .idx      (cur_idx),
        .reg_out  (cur_regs),
        .overflow (cur_ovf)
    );

    assign cur_bit    = XLEN'(1) << cur_idx;
    assign pend_after = pend_q & ~cur_bit;
    assign accept_in  = (state_q == S_IDLE) && in_valid;
    assign issue_fire = (state_q == S_RUN) && !cur_ovf && fifo_ready;

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (in_valid) begin
                    state_nx = (|eff_mask) ? S_RUN : S_DONE;
                end
            end
            S_RUN: begin
                if (cur_ovf) begin
                    state_nx = S_FAULT;
                end else if (fifo_ready && (pend_after == '0)) begin
                    state_nx = S_DONE;
                end
            end
            S_DONE:  state_nx = S_IDLE;
            S_FAULT: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Instruction and pending-element registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q  <= '0;
            base_q <= '0;
            pend_q <= '0;
        end else if (accept_in) begin
            opc_q              <= in_opcode;
            base_q[PIE_OP_RD]  <= in_rd;
            base_q[PIE_OP_RS1] <= in_rs1;
            base_q[PIE_OP_RS2] <= in_rs2;
            pend_q             <= eff_mask;
        end else if (issue_fire) begin
            pend_q <= pend_after;
        end
    end

    // Outputs.
    always_comb begin
        in_ready   = (state_q == S_IDLE);
        uop_valid  = (state_q == S_RUN) && !cur_ovf;
        uop_opcode = opc_q;
        uop_rd     = cur_regs[PIE_OP_RD];
        uop_rs1    = cur_regs[PIE_OP_RS1];
        uop_rs2    = cur_regs[PIE_OP_RS2];
        uop_elem   = cur_idx;
        done       = (state_q == S_DONE) || (state_q == S_FAULT);
        error      = (state_q == S_FAULT);
    end
endmodule

// File: rtl/pie_checker.sv
module pie_checker #(
    parameter int unsigned OPC_W = 7,
    parameter int unsigned REG_W = 5,
    parameter int unsigned IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             fifo_ready,
    input logic             uop_valid,
    input logic [OPC_W-1:0] uop_opcode,
    input logic [REG_W-1:0] uop_rd,
    input logic [REG_W-1:0] uop_rs1,
    input logic [REG_W-1:0] uop_rs2,
    input logic [IDX_W-1:0] uop_elem,
    input logic             done,
    input logic             error
);
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !fifo_ready) |=> (uop_valid && $stable(uop_opcode) &&
            $stable(uop_rd) && $stable(uop_rs1) && $stable(uop_rs2) &&
            $stable(uop_elem)));

    p_elem_ascend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && fifo_ready) |=> (!uop_valid || (uop_elem > $past(uop_elem))));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !uop_valid);

    p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid || done) |-> !in_ready);

    p_error_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);
endmodule

bind pred_issue_expander pie_checker #(
    .OPC_W (OPC_W),
    .REG_W (REG_W),
    .IDX_W (IDX_W)
) u_pie_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .fifo_ready (fifo_ready),
    .uop_valid  (uop_valid),
    .uop_opcode (uop_opcode),
    .uop_rd     (uop_rd),
    .uop_rs1    (uop_rs1),
    .uop_rs2    (uop_rs2),
    .uop_elem   (uop_elem),
    .done       (done),
    .error      (error)
);

// File: tb/pred_issue_expander_test.sv
module pred_issue_expander_test;
    localparam int XLEN  = 32;
    localparam int NREG  = 32;
    localparam int OPC_W = 7;
    localparam int REG_W = $clog2(NREG);
    localparam int IDX_W = $clog2(XLEN);
    localparam int VL_W  = $clog2(XLEN + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic             in_ready;
    logic [OPC_W-1:0] in_opcode;
    logic [REG_W-1:0] in_rd, in_rs1, in_rs2;
    logic [VL_W-1:0]  in_vl;
    logic [XLEN-1:0]  in_mask;
    logic             fifo_ready;
    logic             uop_valid;
    logic [OPC_W-1:0] uop_opcode;
    logic [REG_W-1:0] uop_rd, uop_rs1, uop_rs2;
    logic [IDX_W-1:0] uop_elem;
    logic             done, error;

    always #10 clk = ~clk;

    pred_issue_expander #(.XLEN(XLEN), .NREG(NREG), .OPC_W(OPC_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_vl(in_vl), .in_mask(in_mask), .fifo_ready(fifo_ready),
        .uop_valid(uop_valid), .uop_opcode(uop_opcode), .uop_rd(uop_rd),
        .uop_rs1(uop_rs1), .uop_rs2(uop_rs2), .uop_elem(uop_elem),
        .done(done), .error(error)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model.
    typedef enum int {M_IDLE, M_RUN, M_DONE, M_ERR} mst_e;
    mst_e             m_st = M_IDLE;
    int               q[$];
    bit               m_err = 0;
    int               m_opc, m_rd, m_rs1, m_rs2;
    bit               model_on = 0;
    bit               prev_stall = 0;

    function automatic bool_ovf(input int b0, input int b1, input int b2, input int i);
        return (b0 + i > NREG - 1) || (b1 + i > NREG - 1) || (b2 + i > NREG - 1);
    endfunction

    always @(negedge clk) begin
        if (model_on) begin
            bit    e_ready, e_valid, e_done, e_err;
            string ftag;
            e_ready = (m_st == M_IDLE);
            e_valid = (m_st == M_RUN) && (q.size() > 0);
            e_done  = (m_st == M_DONE) || (m_st == M_ERR);
            e_err   = (m_st == M_ERR);
            chk(in_ready == e_ready, "R7", "in_ready", in_ready, e_ready);
            chk(uop_valid == e_valid, cur_req, "uop_valid", uop_valid, e_valid);
            if (e_valid && uop_valid) begin
                ftag = prev_stall ? "R5" : "R3";
                chk(uop_elem == q[0], ftag, "uop_elem", uop_elem, q[0]);
                chk(uop_opcode == m_opc, ftag, "uop_opcode", uop_opcode, m_opc);
                chk(uop_rd == m_rd + q[0], ftag, "uop_rd", uop_rd, m_rd + q[0]);
                chk(uop_rs1 == m_rs1 + q[0], ftag, "uop_rs1", uop_rs1, m_rs1 + q[0]);
                chk(uop_rs2 == m_rs2 + q[0], ftag, "uop_rs2", uop_rs2, m_rs2 + q[0]);
            end
            chk(done == e_done, m_err ? "R8" : "R6", "done", done, e_done);
            chk(error == e_err, "R8", "error", error, e_err);

            prev_stall = e_valid && !fifo_ready;
            case (m_st)
                M_IDLE: if (in_valid) begin
                    int vle;
                    q.delete();
                    m_err = 0;
                    m_opc = int'(in_opcode);
                    m_rd  = int'(in_rd);
                    m_rs1 = int'(in_rs1);
                    m_rs2 = int'(in_rs2);
                    vle   = (int'(in_vl) > XLEN) ? XLEN : int'(in_vl);
                    for (int i = 0; i < vle; i++) begin
                        if (in_mask[i]) begin
                            if (bool_ovf(m_rd, m_rs1, m_rs2, i)) begin
                                m_err = 1;
                                break;
                            end
                            q.push_back(i);
                        end
                    end
                    m_st = (q.size() > 0 || m_err) ? M_RUN : M_DONE;
                end
                M_RUN: begin
                    if (q.size() > 0) begin
                        if (fifo_ready) begin
                            void'(q.pop_front());
                            if (q.size() == 0) m_st = m_err ? M_RUN : M_DONE;
                        end
                    end else begin
                        m_st = M_ERR;
                    end
                end
                default: m_st = M_IDLE;
            endcase
        end
    end

    // mode 0: always ready, 1: random, 2: alternating
    task automatic do_instr(input int opc, input int rd, input int rs1, input int rs2,
                            input int vl, input logic [XLEN-1:0] mask,
                            input int mode, input bit junk, input string tag);
        int cyc = 0;
        @(posedge clk); #2;
        while (m_st != M_IDLE) begin @(posedge clk); #2; end
        cur_req    = tag;
        in_valid   = 1'b1;
        in_opcode  = OPC_W'(opc);
        in_rd      = REG_W'(rd);
        in_rs1     = REG_W'(rs1);
        in_rs2     = REG_W'(rs2);
        in_vl      = VL_W'(vl);
        in_mask    = mask;
        fifo_ready = 1'b1;
        @(posedge clk); #2;
        in_valid = 1'b0;
        while (m_st != M_IDLE) begin
            cyc++;
            case (mode)
                0:       fifo_ready = 1'b1;
                1:       fifo_ready = 1'($urandom_range(0, 1));
                default: fifo_ready = cyc[0];
            endcase
            if (junk) begin
                // R7: offered while busy, must be ignored
                in_valid  = 1'b1;
                in_opcode = ~OPC_W'(opc);
                in_rd     = REG_W'(0);
                in_vl     = VL_W'(XLEN);
                in_mask   = '1;
            end
            @(posedge clk); #2;
        end
        in_valid   = 1'b0;
        fifo_ready = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_opcode = '0; in_rd = '0; in_rs1 = '0;
        in_rs2 = '0; in_vl = '0; in_mask = '0; fifo_ready = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9", "reset in_ready", in_ready, 1);
        chk(uop_valid == 1'b0, "R9", "reset uop_valid", uop_valid, 0);
        chk(done == 1'b0, "R9", "reset done", done, 0);
        chk(error == 1'b0, "R9", "reset error", error, 0);
        model_on = 1;

        do_instr(7'h13, 0, 8, 16, 8, 32'h0000_00FF, 0, 0, "R1");   // dense
        do_instr(7'h33, 1, 9, 20, 8, 32'h0000_00A5, 0, 0, "R4");   // sparse, condensed
        do_instr(7'h0B, 2, 3, 4, 4, 32'h0000_00FF, 0, 0, "R2");    // bits above VL
        do_instr(7'h21, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, "R6");    // VL zero
        do_instr(7'h22, 5, 5, 5, 16, 32'h0000_0000, 0, 0, "R6");   // empty mask
        do_instr(7'h23, 0, 0, 0, 32, 32'hFFFF_FFFF, 0, 0, "R1");   // full length
        do_instr(7'h24, 0, 0, 0, 40, 32'h8000_0001, 0, 0, "R2");   // VL above XLEN
        do_instr(7'h25, 28, 0, 0, 8, 32'h0000_0025, 0, 0, "R8");   // rd overflow at element 5
        do_instr(7'h26, 0, 0, 30, 8, 32'h0000_000C, 0, 0, "R8");   // rs2 overflow first element
        do_instr(7'h27, 31, 1, 1, 2, 32'h0000_0002, 0, 0, "R8");   // rd overflow only element
        do_instr(7'h28, 4, 6, 8, 12, 32'h0000_0B6D, 2, 0, "R5");   // alternating stalls
        do_instr(7'h29, 2, 4, 6, 10, 32'h0000_03F7, 1, 1, "R7");   // in_valid while busy
        for (int k = 0; k < 25; k++) begin
            do_instr(int'($urandom_range(0, 127)), int'($urandom_range(0, 31)),
                     int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                     int'($urandom_range(0, 40)), $urandom, 1, k[0], "R1");
        end
        do_instr(7'h11, 0, 0, 0, 24, 32'h00F0_0F0F, 1, 0, "R5");
        repeat (4) @(posedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule